// File: doc/BRIEF.md
# Read Strobe Centering Trainer

This block trains the read capture delay of a memory interface. After write leveling has finished, and as the last training step before the interface reports itself ready, a single start pulse makes the trainer step the 5-bit read strobe delay tap through every setting from 0 to 31. At each setting it asks for a programmable number of reads of a known alternating pattern. It compares every returned word with the pattern it expects and records one pass/fail bit for that tap.

When all 32 taps have been tried, the trainer looks through the 32-bit pass map for the longest unbroken run of passing taps and programs the tap in the middle of that run. The middle of the run is where the capture edge has the most margin on both sides. The tap output drives the delay line directly: it shows the tap under test during the sweep and the trained tap afterwards. Reads are requested with a one-cycle request pulse. The reply comes back as a valid-qualified data word after whatever read latency the path has. A reply that does not arrive in time counts as a failure.

Top module: `rdq_center_trainer`

## Requirements
- R1: After reset, `busy`, `done`, `fail` and `rd_req` are 0, and `rd_tap` and `win_width` are 0.
- R2: A `train_start` pulse while `busy` is 0 starts a sweep and latches `reads_per_tap`. A `train_start` during a sweep is ignored, so the sweep still makes exactly 32×N read requests.
- R3: Taps are visited in ascending order from 0 to 31, with N reads per tap. N is `reads_per_tap`, and a value of 0 is treated as 1. While a tap's reads are in flight, `rd_tap` shows that tap.
- R4: Read k of a tap (k counted from 0) expects 0x55555555 when k is even and 0xAAAAAAAA when k is odd. A mismatch in any data bit on any read marks the tap as failing.
- R5: A reply counts only if `rd_valid` is seen within TIMEOUT (default 16) cycles after the request cycle. A reply in exactly the last allowed cycle is accepted. A later reply, or no reply, fails the tap, and `rd_valid` outside a wait is ignored.
- R6: The chosen window is the longest run of consecutive passing taps. When two runs have equal length, the one with the lower tap indices wins.
- R7: The trained tap equals the window's first tap plus floor(width/2). `win_width` reports the run length, from 1 to 32.
- R8: When the sweep ends, `done` rises and `busy` falls in the same cycle, and `rd_tap` then shows the trained tap. `done` stays high until the next accepted start.
- R9: If no tap passes, `fail` and `done` are set, `win_width` is 0, and `rd_tap` keeps the previously trained tap (0 if there is none).
- R10: `rd_req` is a single-cycle pulse. Only one read is outstanding at a time, and the next request comes only after the reply or the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| train_start | input | 1 | Pulse that begins a sweep |
| reads_per_tap | input | 4 | Reads issued per tap (0 means 1) |
| rd_valid | input | 1 | Qualifies `rd_data` as a read reply |
| rd_data | input | 32 | Captured read data |
| rd_req | output | 1 | One-cycle read request |
| rd_tap | output | 5 | Read strobe delay tap applied to the delay line |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Training finished |
| fail | output | 1 | No passing tap was found |
| win_width | output | 6 | Width of the selected passing window |

## Verification
The case that needs care is a reply that lands in the same cycle as the timeout expiry. In that case the reply must win and its data must be compared. The bench provokes this by holding some taps' replies until exactly the TIMEOUT-th cycle after the request, and those taps must pass. A neighbouring tap replies one cycle later, so its `rd_valid` falls into the bookkeeping cycle after expiry. That tap must fail, and the late pulse must not count as a reply to the next read. A scoreboard predicts the trained tap, width and fail flag from its own map of which taps it corrupts. It compares them when `done` rises, and it also checks the request count and the tap shown with every request.

// File: rtl/rdq_center_pkg.sv
// Shared types for the read strobe centering trainer.
// Assumes: nothing beyond the standard language.
package rdq_center_pkg;

    // Sweep controller phases
    typedef enum logic [2:0] {
        SW_IDLE  = 3'd0,
        SW_ISSUE = 3'd1,
        SW_WAIT  = 3'd2,
        SW_NEXT  = 3'd3,
        SW_EVAL  = 3'd4
    } sweep_state_t;

endpackage

// File: rtl/rdq_sweep_ctrl.sv
// Steps the read tap from 0 to the last tap, issuing RCNT reads per tap,
// comparing each reply with an alternating pattern and building a pass map.
// Assumes: one read outstanding; replies arrive with rd_valid after the
// request cycle; a reply outside the wait phase is meaningless.
module rdq_sweep_ctrl
    import rdq_center_pkg::*;
#(
    parameter int TAP_W   = 5,
    parameter int DATA_W  = 32,
    parameter int RCNT_W  = 4,
    parameter int TIMEOUT = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [RCNT_W-1:0]     reads_per_tap,
    input  logic                  rd_valid,
    input  logic [DATA_W-1:0]     rd_data,
    output logic                  rd_req,
    output logic [TAP_W-1:0]      sweep_tap,
    output logic                  busy,
    output logic                  sweep_end,
    output logic [(1<<TAP_W)-1:0] pass_map
);
    localparam int NT    = 1 << TAP_W;
    localparam int TMR_W = $clog2(TIMEOUT + 1);
    localparam logic [TAP_W-1:0] LAST_TAP = TAP_W'(NT - 1);
    localparam logic [DATA_W-1:0] PAT_EVEN = {(DATA_W/2){2'b01}};
    localparam logic [DATA_W-1:0] PAT_ODD  = {(DATA_W/2){2'b10}};

    sweep_state_t         state_q;
    logic [TAP_W-1:0]     tap_q;
    logic [RCNT_W-1:0]    ridx_q;
    logic [RCNT_W-1:0]    nreads_q;
    logic [TMR_W-1:0]     timer_q;
    logic                 ok_q;
    logic [NT-1:0]        map_q;
    logic [DATA_W-1:0]    expect_w;

    // Expected word for the current read within the tap
    always_comb expect_w = ridx_q[0] ? PAT_ODD : PAT_EVEN;

    // Sweep sequencing, reply checking and pass-map recording
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SW_IDLE;
            tap_q    <= '0;
            ridx_q   <= '0;
            nreads_q <= RCNT_W'(1);
            timer_q  <= '0;
            ok_q     <= 1'b1;
            map_q    <= '0;
        end else begin
            case (state_q)
                SW_IDLE: begin
                    if (start) begin
                        tap_q    <= '0;
                        ridx_q   <= '0;
                        ok_q     <= 1'b1;
                        map_q    <= '0;
                        nreads_q <= (reads_per_tap == '0) ? RCNT_W'(1) : reads_per_tap;
                        state_q  <= SW_ISSUE;
                    end
                end
                SW_ISSUE: begin
                    timer_q <= '0;
                    state_q <= SW_WAIT;
                end
                SW_WAIT: begin
                    if (rd_valid) begin
                        if (rd_data != expect_w) ok_q <= 1'b0;
                        state_q <= SW_NEXT;
                    end else if (timer_q == TMR_W'(TIMEOUT - 1)) begin
                        ok_q    <= 1'b0;
                        state_q <= SW_NEXT;
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                SW_NEXT: begin
                    if (ridx_q == nreads_q - RCNT_W'(1)) begin
                        map_q[tap_q] <= ok_q;
                        ok_q         <= 1'b1;
                        ridx_q       <= '0;
                        if (tap_q == LAST_TAP) begin
                            state_q <= SW_EVAL;
                        end else begin
                            tap_q   <= tap_q + 1'b1;
                            state_q <= SW_ISSUE;
                        end
                    end else begin
                        ridx_q  <= ridx_q + 1'b1;
                        state_q <= SW_ISSUE;
                    end
                end
                SW_EVAL: state_q <= SW_IDLE;
                default: state_q <= SW_IDLE;
            endcase
        end
    end

    // Output decode of the phase
    always_comb begin
        rd_req    = (state_q == SW_ISSUE);
        busy      = (state_q != SW_IDLE);
        sweep_end = (state_q == SW_EVAL);
        sweep_tap = tap_q;
        pass_map  = map_q;
    end

    // R10
    rd_req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R5
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SW_WAIT) |-> (timer_q < TMR_W'(TIMEOUT)));

    // R3
    tap_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy) && (sweep_tap != $past(sweep_tap)))
            |-> (sweep_tap == TAP_W'($past(sweep_tap) + 1'b1)));

endmodule

// File: rtl/rdq_window_find.sv
// Scans a pass map for the longest run of set bits; on equal lengths the
// lowest run is kept. Returns run start, run length and the centre tap.
// Assumes: pure combinational; map is stable when the result is used.
module rdq_window_find #(
    parameter int TAP_W = 5
) (
    input  logic [(1<<TAP_W)-1:0] pass_map,
    output logic [TAP_W-1:0]      win_start,
    output logic [TAP_W:0]        win_len,
    output logic [TAP_W-1:0]      win_center
);
    localparam int NT = 1 << TAP_W;

    logic [TAP_W:0] run;

    // Running-length scan; strict compare keeps the earliest widest run
    always_comb begin
        run       = '0;
        win_len   = '0;
        win_start = '0;
        for (int i = 0; i < NT; i++) begin
            if (pass_map[i]) run = run + 1'b1;
            else             run = '0;
            if (run > win_len) begin
                win_len   = run;
                win_start = TAP_W'(i + 1 - int'(run));
            end
        end
        win_center = win_start + TAP_W'(win_len >> 1);
    end

endmodule

// File: rtl/rdq_center_trainer.sv
// Read strobe centering trainer top: runs the tap sweep, selects the centre
// of the widest passing window and holds the trained tap for the delay line.
// Assumes: train_start arrives after write leveling; rd_tap feeds the read
// capture delay line directly.
module rdq_center_trainer #(
    parameter int TAP_W   = 5,
    parameter int DATA_W  = 32,
    parameter int RCNT_W  = 4,
    parameter int TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_start,
    input  logic [RCNT_W-1:0] reads_per_tap,
    input  logic              rd_valid,
    input  logic [DATA_W-1:0] rd_data,
    output logic              rd_req,
    output logic [TAP_W-1:0]  rd_tap,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [TAP_W:0]    win_width
);
    localparam int NT = 1 << TAP_W;

    logic [TAP_W-1:0] sweep_tap;
    logic             sweep_end;
    logic [NT-1:0]    pass_map;
    logic [TAP_W-1:0] best_start;
    logic [TAP_W:0]   best_len;
    logic [TAP_W-1:0] best_center;
    logic [TAP_W-1:0] chosen_q;

    rdq_sweep_ctrl #(
        .TAP_W  (TAP_W),
        .DATA_W (DATA_W),
        .RCNT_W (RCNT_W),
        .TIMEOUT(TIMEOUT)
    ) u_sweep (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (train_start),
        .reads_per_tap(reads_per_tap),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .rd_req       (rd_req),
        .sweep_tap    (sweep_tap),
        .busy         (busy),
        .sweep_end    (sweep_end),
        .pass_map     (pass_map)
    );

    rdq_window_find #(
        .TAP_W(TAP_W)
    ) u_find (
        .pass_map  (pass_map),
        .win_start (best_start),
        .win_len   (best_len),
        .win_center(best_center)
    );

    // Result registers: latch trained tap and flags at the end of a sweep
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chosen_q  <= '0;
            done      <= 1'b0;
            fail      <= 1'b0;
            win_width <= '0;
        end else if (train_start && !busy) begin
            done <= 1'b0;
            fail <= 1'b0;
        end else if (sweep_end) begin
            done <= 1'b1;
            if (best_len == '0) begin
                fail      <= 1'b1;
                win_width <= '0;
            end else begin
                fail      <= 1'b0;
                chosen_q  <= best_center;
                win_width <= best_len;
            end
        end
    end

    // Tap to the delay line: under test while sweeping, trained otherwise
    always_comb rd_tap = busy ? sweep_tap : chosen_q;

    // R8
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    // R9
    fail_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (done && (win_width == '0)));

    // R9
    fail_hold_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && fail) |-> (chosen_q == $past(chosen_q)));

    // R7
    tap_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fail) |-> pass_map[rd_tap]);

    // R6
    width_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_width <= (TAP_W+1)'(NT));

endmodule

// File: tb/rdq_center_trainer_tb.sv
module rdq_center_trainer_tb;
    localparam int TMO = 16;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        train_start;
    logic [3:0]  reads_per_tap;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic        rd_req;
    logic [4:0]  rd_tap;
    logic        busy, done, fail;
    logic [5:0]  win_width;

    rdq_center_trainer u_dut (
        .clk(clk), .rst_n(rst_n), .train_start(train_start),
        .reads_per_tap(reads_per_tap), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_req(rd_req), .rd_tap(rd_tap), .busy(busy), .done(done),
        .fail(fail), .win_width(win_width)
    );

    always #10 clk = ~clk;

    typedef struct {
        int tap;
        int width;
        bit fl;
        int nreq;
    } exp_t;

    exp_t exp_q[$];
    int   errors = 0;
    int   checks = 0;
    int   mode[32];
    int   neff = 1;
    int   req_count = 0;
    int   prev_tap = 0;
    bit   finished = 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic set_range(input int lo, input int hi, input int m);
        for (int i = lo; i <= hi; i++) mode[i] = m;
    endtask

    function automatic bit tap_passes(input int m);
        case (m)
            0, 5:    return 1'b1;
            3:       return (neff == 1);
            default: return 1'b0;
        endcase
    endfunction

    // Responder: modes 0 good, 1 bit error, 2 silent, 3 always 0x55..,
    // 4 one cycle late, 5 exactly at timeout
    initial begin
        int cnt = 0;
        int d;
        int ridx;
        logic [31:0] good;
        logic [31:0] resp = '0;
        rd_valid = 1'b0;
        rd_data  = '0;
        forever begin
            @(negedge clk);
            rd_valid = 1'b0;
            if (cnt > 0) begin
                cnt--;
                if (cnt == 0) begin
                    rd_valid = 1'b1;
                    rd_data  = resp;
                end
            end
            if (rd_req) begin
                // R3: tap shown with each request follows the sweep order
                check(rd_tap == 5'(req_count / neff), "R3 tap", rd_tap, req_count / neff);
                ridx = req_count % neff;
                good = ridx[0] ? 32'hAAAA_AAAA : 32'h5555_5555;
                case (mode[rd_tap])
                    0: begin resp = good; d = 3; end
                    1: begin resp = good ^ 32'h0000_0080; d = 3; end
                    2: begin resp = good; d = 0; end
                    3: begin resp = 32'h5555_5555; d = 2; end
                    4: begin resp = good; d = TMO + 1; end
                    default: begin resp = good; d = TMO; end
                endcase
                cnt = d;
                req_count++;
            end
        end
    end

    // Monitor: pop expectation at every rising done
    initial begin
        bit done_prev = 0;
        exp_t e;
        forever begin
            @(negedge clk);
            if (done && !done_prev) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R8 unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    check(rd_tap == 5'(e.tap), "R7/R8 trained tap", rd_tap, e.tap);
                    check(win_width == 6'(e.width), "R6/R7 width", win_width, e.width);
                    check(fail == e.fl, "R9 fail flag", fail, e.fl);
                    check(req_count == e.nreq, "R2/R10 request count", req_count, e.nreq);
                    check(!busy, "R8 busy low at done", busy, 0);
                end
            end
            done_prev = done;
        end
    end

    // Driver: predict result from the tap modes, then run a sweep
    task automatic run_training(input int rpt, input bit extra_start);
        exp_t e;
        int best_w = 0;
        int best_s = 0;
        int len;
        neff = (rpt == 0) ? 1 : rpt;
        for (int s = 0; s < 32; s++) begin
            len = 0;
            while (s + len < 32 && tap_passes(mode[s + len])) len++;
            if (len > best_w) begin best_w = len; best_s = s; end
        end
        e.fl    = (best_w == 0);
        e.width = best_w;
        e.tap   = e.fl ? prev_tap : best_s + best_w / 2;
        e.nreq  = 32 * neff;
        prev_tap = e.tap;
        exp_q.push_back(e);
        @(negedge clk);
        req_count     = 0;
        reads_per_tap = 4'(rpt);
        train_start   = 1'b1;
        @(negedge clk);
        train_start   = 1'b0;
        check(busy && !done, "R2 busy after start", busy, 1);
        if (extra_start) begin
            repeat (40) @(negedge clk);
            reads_per_tap = 4'd5;
            train_start   = 1'b1;
            @(negedge clk);
            train_start   = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (2) @(negedge clk);
        // R8: done holds until a new start
        check(done && rd_tap == 5'(e.tap), "R8 done held", rd_tap, e.tap);
    endtask

    initial begin
        rst_n = 1'b0;
        train_start = 1'b0;
        reads_per_tap = 4'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(!busy, "R1 busy", busy, 0);
        check(!done, "R1 done", done, 0);
        check(!fail, "R1 fail", fail, 0);
        check(!rd_req, "R1 rd_req", rd_req, 0);
        check(rd_tap == 0, "R1 rd_tap", rd_tap, 0);
        check(win_width == 0, "R1 win_width", win_width, 0);

        // R2/R4: single window, two reads per tap, start repeated mid-sweep
        set_range(0, 31, 1); set_range(10, 20, 0);
        run_training(2, 1'b1);
        // R6: equal windows, lower wins; reads 0 treated as 1 (R3)
        set_range(0, 31, 1); set_range(3, 7, 0); set_range(20, 24, 0);
        run_training(0, 1'b0);
        // R7: whole range passes
        set_range(0, 31, 0);
        run_training(1, 1'b0);
        // R4: odd-read pattern error splits the window; silent taps (R5)
        set_range(0, 31, 2); set_range(0, 9, 0); mode[4] = 3;
        run_training(2, 1'b0);
        // R4: same tap passes when only even reads happen
        set_range(0, 31, 1); set_range(0, 9, 0); mode[4] = 3;
        run_training(1, 1'b0);
        // R5: reply at the timeout cycle accepted, one later rejected
        set_range(0, 31, 1); set_range(8, 12, 5); set_range(13, 15, 0);
        mode[16] = 4; mode[17] = 0;
        run_training(3, 1'b0);
        // R9: nothing passes, trained tap kept
        set_range(0, 31, 1); set_range(0, 3, 2);
        run_training(1, 1'b0);
        // R6/R7: window touching the top tap beats a single low tap
        set_range(0, 31, 1); mode[0] = 0; set_range(28, 31, 0);
        run_training(1, 1'b0);
        // R6: single-tap windows at both ends tie, lower wins
        set_range(0, 31, 1); mode[0] = 0; mode[31] = 0;
        run_training(1, 1'b0);

        check(exp_q.size() == 0, "R8 all sweeps completed", exp_q.size(), 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(negedge clk);
        if (!finished) begin
            check(1'b0, "watchdog expired", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule